// File: doc/BRIEF.md
# I2C Target Byte Engine with Busy Refusal

This block is the bus-facing half of a serial memory or register target on an I2C bus. It samples SCL and SDA with a much faster system clock and finds Start and Stop conditions in the sampled lines. It shifts bytes in most significant bit first and answers each accepted byte by pulling SDA low. For reads it asks the user logic for a byte, one byte at a time, and shifts that byte out. SDA is driven only as an open-drain pull-low enable.

A `busy` input tells the engine that an internal write cycle is running. While `busy` is high the engine refuses every byte it would otherwise accept, its own address byte included. A controller can therefore poll the target with address bytes until one of them is acknowledged. A read sequence ends when the controller leaves the acknowledge bit high. The engine then lets go of SDA and ignores the bus until the next Start or Stop.

The controller sets how many bytes pass between Start and Stop, and the engine puts no limit on that number. The first byte after a Start carries the 7-bit target address in bits 7:1 and the direction in bit 0. Bit 0 is 1 for a read.

The state machine has eight states:
- IDLE: waits for a Start.
- ADDR: receives the address byte.
- ADDR_ACK: acknowledges the address.
- WRITE: receives a data byte.
- WRITE_ACK: acknowledges a data byte.
- READ: sends a data byte.
- READ_ACK: waits for the controller's acknowledge.
- WAIT: ignores the bus until a Start or Stop.

The transitions are these:
- Any state moves to IDLE on a Stop. A Stop takes priority over everything else.
- Any state moves to ADDR on a Start.
- ADDR moves to ADDR_ACK on the SCL fall after the eighth bit if the address matches and `busy` is low. Otherwise it moves to WAIT.
- ADDR_ACK moves to READ or WRITE on the next SCL fall, chosen by the R/W bit.
- WRITE moves to WRITE_ACK on the SCL fall after the eighth bit, or to WAIT if `busy` is high.
- WRITE_ACK returns to WRITE on the next SCL fall.
- READ moves to READ_ACK on the SCL fall after the eighth bit.
- READ_ACK moves to WAIT on an SCL rise that samples SDA high. With SDA low on that rise it stays in READ_ACK, and it moves to READ on the next SCL fall.

Top module: `i2c_target_engine`

## Requirements
- R1: After reset, `sda_oe`, `rx_valid` and `tx_req` are low and the engine is idle.
- R2: A Start (SDA falls while SCL is high) puts the engine into address reception with the bit count cleared. This holds even in the middle of a byte. The partial byte is never presented.
- R3: A Stop (SDA rises while SCL is high) returns the engine to idle with SDA released. Bytes clocked after a Stop and without a new Start are not acknowledged.
- R4: A bit is sampled on each SCL rise, most significant bit first. In the address byte, bits 7:1 are the address and bit 0 is R/W, with 1 meaning read.
- R5: When the address equals `TGT_ADDR` and `busy` is low, SDA is pulled low from the SCL fall after the eighth bit until the next SCL fall. On a mismatch no acknowledge is given and the rest of the transfer is ignored.
- R6: While `busy` is high, neither address bytes nor write data bytes are acknowledged. A refused data byte is not presented on `rx_data`.
- R7: Each accepted write byte appears on `rx_data` with a one-cycle `rx_valid` strobe and is then acknowledged. Any number of bytes can follow one address.
- R8: Before each read byte, `tx_req` pulses for one cycle and `tx_data` is taken on the following cycle. The bits go out most significant first, with `sda_oe` high meaning a 0. `sda_oe` rises only while the sampled SCL is low.
- R9: After a read byte, SDA is released for the acknowledge clock. If the controller acknowledges, the next byte is requested. If it does not, the engine stops driving and ignores the bus until a Start or Stop, with no further `tx_req`.
- R10: A repeated Start without a Stop can change the direction from write to read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when high |
| busy | input | 1 | Internal write cycle in progress; refuse all bytes |
| rx_data | output | DATA_W | Last received write byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| tx_req | output | 1 | One-cycle request for the next read byte |
| tx_data | input | DATA_W | Read byte, sampled the cycle after `tx_req` |

## Verification
A level change on a bus pin passes through two synchronizer flops and then the edge stage. State, `sda_oe`, `rx_valid` and `tx_req` therefore change on the third rising clock after the pin change. The bench holds each SCL phase for eight clocks and reads the wired-AND SDA line four clocks into the SCL high phase, so an acknowledge or data bit is always settled when it is read. The strobes are collected by monitors that run every cycle, and they are compared only after the byte that caused them has finished clocking. Refusals are checked at the wired SDA line, and by confirming that no new strobe was logged.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WRITE,
        ST_WRITE_ACK,
        ST_READ,
        ST_READ_ACK,
        ST_WAIT
    } tgt_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] dprev
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    chain[s] <= '1;
                else if (s == 0)
                    chain[s] <= din;
                else
                    chain[s] <= chain[(s > 0) ? s - 1 : 0];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dprev <= '1;
        else
            dprev <= chain[STAGES-1];
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic scl_s,
    input  logic scl_d,
    input  logic sda_s,
    input  logic sda_d,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    always_comb begin
        scl_rise = scl_s & ~scl_d;
        scl_fall = ~scl_s & scl_d;
        start_ev = scl_s & scl_d & sda_d & ~sda_s;
        stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int          ADDR_W   = 7,
    parameter int          DATA_W   = 8,
    parameter logic [6:0]  TGT_ADDR = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              sda_s,
    input  logic              busy,
    input  logic [DATA_W-1:0] tx_data,
    output logic              sda_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              tx_req,
    output tgt_state_t        state
);
    localparam int                CNT_W    = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(DATA_W);

    tgt_state_t        state_n;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] rxsh;
    logic [DATA_W-1:0] txsh;
    logic              load_pend;
    logic              byte_done;
    logic              addr_ok;

    assign byte_done = scl_fall && (cnt == CNT_FULL);
    assign addr_ok   = (rxsh[DATA_W-1 -: ADDR_W] == TGT_ADDR[ADDR_W-1:0]) && !busy;

    // next-state logic
    always_comb begin
        state_n = state;
        if (stop_ev) begin
            state_n = ST_IDLE;
        end else if (start_ev) begin
            state_n = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE, ST_WAIT: state_n = state;
                ST_ADDR:      if (byte_done) state_n = addr_ok ? ST_ADDR_ACK : ST_WAIT;
                ST_ADDR_ACK:  if (scl_fall)  state_n = rxsh[0] ? ST_READ : ST_WRITE;
                ST_WRITE:     if (byte_done) state_n = busy ? ST_WAIT : ST_WRITE_ACK;
                ST_WRITE_ACK: if (scl_fall)  state_n = ST_WRITE;
                ST_READ:      if (byte_done) state_n = ST_READ_ACK;
                ST_READ_ACK: begin
                    if (scl_rise && sda_s) state_n = ST_WAIT;
                    else if (scl_fall)     state_n = ST_READ;
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            rxsh      <= '0;
            txsh      <= '0;
            load_pend <= 1'b0;
        end else begin
            state     <= state_n;
            load_pend <= tx_req;
            if (start_ev || state_n != state)
                cnt <= '0;
            else if (scl_rise && (state == ST_ADDR || state == ST_WRITE || state == ST_READ))
                cnt <= cnt + 1'b1;
            if (scl_rise && (state == ST_ADDR || state == ST_WRITE))
                rxsh <= {rxsh[DATA_W-2:0], sda_s};
            if (load_pend)
                txsh <= tx_data;
            else if (scl_fall && state_n == ST_READ)
                txsh <= {txsh[DATA_W-2:0], 1'b1};
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe   <= 1'b0;
            rx_valid <= 1'b0;
            tx_req   <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= 1'b0;
            tx_req   <= 1'b0;
            if (stop_ev || start_ev) begin
                sda_oe <= 1'b0;
            end else begin
                if (scl_fall) begin
                    unique case (state_n)
                        ST_ADDR_ACK, ST_WRITE_ACK: sda_oe <= 1'b1;
                        ST_READ:                   sda_oe <= ~txsh[DATA_W-1];
                        default:                   sda_oe <= 1'b0;
                    endcase
                end
                if (state == ST_WRITE && state_n == ST_WRITE_ACK) begin
                    rx_valid <= 1'b1;
                    rx_data  <= rxsh;
                end
                if ((state == ST_ADDR && state_n == ST_ADDR_ACK && rxsh[0]) ||
                    (state == ST_READ_ACK && scl_rise && !sda_s))
                    tx_req <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_target_engine.sv
module i2c_target_engine
    import i2c_tgt_pkg::*;
#(
    parameter int          ADDR_W      = 7,
    parameter int          DATA_W      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [6:0]  TGT_ADDR    = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              busy,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              tx_req,
    input  logic [DATA_W-1:0] tx_data
);
    logic [1:0] lines_s, lines_d;
    logic       scl_s, scl_d, sda_s, sda_d;
    logic       scl_rise, scl_fall, start_ev, stop_ev;
    tgt_state_t state;

    i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  (lines_s),
        .dprev (lines_d)
    );

    assign {scl_s, sda_s} = lines_s;
    assign {scl_d, sda_d} = lines_d;

    i2c_bus_events u_events (
        .scl_s    (scl_s),
        .scl_d    (scl_d),
        .sda_s    (sda_s),
        .sda_d    (sda_d),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_target_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TGT_ADDR(TGT_ADDR)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .sda_s    (sda_s),
        .busy     (busy),
        .tx_data  (tx_data),
        .sda_oe   (sda_oe),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .tx_req   (tx_req),
        .state    (state)
    );
endmodule

// File: rtl/i2c_target_checker.sv
module i2c_target_checker
    import i2c_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_hi,
    input logic       start_ev,
    input logic       stop_ev,
    input logic       busy,
    input logic       sda_oe,
    input logic       rx_valid,
    input logic       tx_req,
    input tgt_state_t state
);
    assert_stop_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == ST_IDLE && !sda_oe));

    assert_start_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && !stop_ev) |=> (state == ST_ADDR && !sda_oe));

    assert_ack_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && (state == ST_ADDR_ACK || state == ST_WRITE_ACK)) |-> !$past(busy));

    assert_oe_rise_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_hi);

    assert_rx_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_tx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> !tx_req);

    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && tx_req));
endmodule

bind i2c_target_engine i2c_target_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_hi   (scl_s),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .busy     (busy),
    .sda_oe   (sda_oe),
    .rx_valid (rx_valid),
    .tx_req   (tx_req),
    .state    (state)
);

// File: tb/i2c_target_engine_test.sv
`timescale 1ns/1ps
module i2c_target_engine_test;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       busy = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       sda_oe, rx_valid, tx_req;
    logic [7:0] rx_data;
    wire        sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] rx_log [64];
    int rx_cnt = 0;
    int tx_cnt = 0;
    logic [7:0] rd_vals [8];

    always #10 clk = ~clk;

    i2c_target_engine uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .busy(busy), .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_req(tx_req), .tx_data(tx_data)
    );

    initial forever begin
        @(negedge clk);
        if (rx_valid) begin
            if (rx_cnt < 64) rx_log[rx_cnt] = rx_data;
            rx_cnt++;
        end
        if (tx_req) begin
            tx_data = rd_vals[tx_cnt % 8];
            tx_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b0; wait_clk(H);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b1; wait_clk(H);
    endtask

    task automatic clock_bit(input logic b, output logic r);
        sda_m = b; wait_clk(H);
        scl_m = 1'b1; wait_clk(H/2);
        @(negedge clk); r = sda_line;
        wait_clk(H/2);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        logic r;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
        clock_bit(1'b1, r);
        acked = !r;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, r);
            b[i] = r;
        end
        clock_bit(!give_ack, r);
    endtask

    task automatic test_reset();
        wait_clk(3);
        @(negedge clk);
        chk(sda_oe == 0, "R1", "sda_oe after reset", int'(sda_oe), 0);
        chk(rx_valid == 0 && tx_req == 0, "R1", "strobes after reset",
            int'({rx_valid, tx_req}), 0);
    endtask

    task automatic test_write();
        bit a;
        int base = rx_cnt;
        bus_start();
        send_byte(8'hA0, a);
        chk(a, "R5", "address ack on write", int'(a), 1);
        for (int i = 0; i < 20; i++) begin
            send_byte(8'(i * 37 + 5), a);
            chk(a, "R7", "data byte ack", int'(a), 1);
        end
        bus_stop();
        chk(rx_cnt - base == 20, "R7", "bytes presented", rx_cnt - base, 20);
        for (int i = 0; i < 20; i++)
            chk(rx_log[base + i] == 8'(i * 37 + 5), "R4", "received byte MSB first",
                int'(rx_log[base + i]), int'(8'(i * 37 + 5)));
        @(negedge clk);
        chk(sda_oe == 0, "R3", "SDA released after stop", int'(sda_oe), 0);
        send_byte(8'hA0, a);
        chk(!a, "R3", "no ack without start", int'(a), 0);
        bus_stop();
    endtask

    task automatic test_read();
        bit a;
        logic [7:0] b;
        logic r;
        int tb0 = tx_cnt;
        int rb0 = rx_cnt;
        for (int k = 0; k < 8; k++) rd_vals[k] = 8'(8'hC5 ^ (k * 29));
        tx_cnt = 0;
        tb0 = 0;
        bus_start();
        send_byte(8'hA1, a);
        chk(a, "R5", "address ack on read", int'(a), 1);
        for (int i = 0; i < 3; i++) begin
            recv_byte(i < 2, b);
            chk(b == rd_vals[i], "R8", "read byte", int'(b), int'(rd_vals[i]));
        end
        chk(tx_cnt - tb0 == 3, "R8", "read requests", tx_cnt - tb0, 3);
        for (int i = 0; i < 9; i++) begin
            clock_bit(1'b1, r);
            chk(r == 1'b1, "R9", "SDA released after NACK", int'(r), 1);
        end
        chk(tx_cnt - tb0 == 3, "R9", "no request after NACK", tx_cnt - tb0, 3);
        chk(rx_cnt == rb0, "R9", "no write strobe in read", rx_cnt - rb0, 0);
        bus_stop();
    endtask

    task automatic test_wrong_addr();
        bit a;
        int rb0 = rx_cnt;
        bus_start();
        send_byte(8'h84, a);
        chk(!a, "R5", "no ack on mismatch", int'(a), 0);
        send_byte(8'h5A, a);
        chk(!a, "R5", "data ignored after mismatch", int'(a), 0);
        chk(rx_cnt == rb0, "R5", "no strobe after mismatch", rx_cnt - rb0, 0);
        bus_stop();
    endtask

    task automatic test_busy();
        bit a;
        int rb0;
        busy = 1'b1;
        bus_start();
        send_byte(8'hA0, a);
        chk(!a, "R6", "address refused while busy", int'(a), 0);
        bus_stop();
        busy = 1'b0;
        bus_start();
        send_byte(8'hA0, a);
        chk(a, "R6", "address ack once idle", int'(a), 1);
        rb0 = rx_cnt;
        busy = 1'b1;
        send_byte(8'h77, a);
        chk(!a, "R6", "data refused while busy", int'(a), 0);
        chk(rx_cnt == rb0, "R6", "refused byte not presented", rx_cnt - rb0, 0);
        busy = 1'b0;
        bus_stop();
    endtask

    task automatic test_restart();
        bit a;
        logic r;
        logic [7:0] b;
        int rb0 = rx_cnt;
        tx_cnt = 0;
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'h11, a);
        chk(a, "R7", "byte before restart acked", int'(a), 1);
        for (int i = 0; i < 4; i++) clock_bit(i[0], r);
        bus_start();
        send_byte(8'hA1, a);
        chk(a, "R2", "address ack after mid-byte start", int'(a), 1);
        recv_byte(1'b0, b);
        chk(b == rd_vals[0], "R10", "read after repeated start", int'(b), int'(rd_vals[0]));
        bus_stop();
        chk(rx_cnt - rb0 == 1, "R2", "partial byte not presented", rx_cnt - rb0, 1);
        chk(rx_log[rb0] == 8'h11, "R2", "byte before restart", int'(rx_log[rb0]), 17);
    endtask

    initial begin
        for (int k = 0; k < 8; k++) rd_vals[k] = 8'(k);
        wait_clk(4);
        rst_n = 1'b1;
        test_reset();
        test_write();
        test_read();
        test_wrong_addr();
        test_busy();
        test_restart();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_clk(200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule